// File: doc/BRIEF.md
# Scaled Complex Multiplier

The block forms the product of two complex numbers, each packed into one 40-bit word with 20-bit two's complement parts. Both the real and the imaginary result are first computed at full precision. Each is then rounded, shifted right by one of two amounts picked by a run-time control bit, and clamped to the 20-bit range. This lets a single multiplier serve coefficient tables kept in two different fixed-point formats.

Operands enter with a valid strobe. The scale selection travels with its operands, so a different shift can be used on every cycle. The result leaves a registered output with its own valid strobe. An optional middle register, on by default, cuts the path between the multipliers and the rounding logic. Latency is two cycles with the middle register and one cycle without it.

Top module: `cmul_top`

## Requirements
- R1: Operands and result are packed with the real part in bits 39:20 and the imaginary part in bits 19:0, each part 20-bit two's complement.
- R2: Before scaling, the real result equals a.re*b.re - a.im*b.im, held at full 41-bit precision with no intermediate loss.
- R3: Before scaling, the imaginary result equals a.re*b.im + a.im*b.re, held at full 41-bit precision.
- R4: When scale_sel is 1, each full-precision part is divided by 2^18.
- R5: When scale_sel is 0, each full-precision part is divided by 2^14.
- R6: Division rounds half up: 2^(s-1) is added and the sum is shifted arithmetically right by s. An exact half therefore rounds toward positive infinity (+0.5 gives 1, -0.5 gives 0).
- R7: A scaled part above 524287 becomes 524287, and one below -524288 becomes -524288.
- R8: out_vld repeats in_vld delayed by the latency (2 cycles with the default middle register). scale_sel is taken in the same cycle as its operands, so back-to-back operations may use different settings.
- R9: While out_vld is low, prod keeps its previous value.
- R10: While rst is high and on the cycle after it, out_vld is 0 and prod is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands and scale_sel are valid this cycle |
| op_a | input | 40 | First complex operand, real in 39:20, imaginary in 19:0 |
| op_b | input | 40 | Second complex operand, same packing |
| scale_sel | input | 1 | 1: divide by 2^18, 0: divide by 2^14 |
| out_vld | output | 1 | prod holds a new result |
| prod | output | 40 | Scaled, rounded, saturated product, same packing |

## Verification
The bench builds the block with its default widths, shifts of 18 and 14, and the middle register on. This fixes the latency at two cycles, and the bench's timing model is written for that. With 20-bit parts the most negative operands push a part past the 20-bit range under both shifts, so clamping is reached at either limit. Operands that land exactly on rounding halves are also possible under both shifts. Back-to-back streams that switch scale_sel on each cycle show that the setting stays paired with its operands through the middle register.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
  // Scale choice carried with each operand pair.
  typedef enum logic {
    SCALE_FINE   = 1'b0,  // smaller shift
    SCALE_COARSE = 1'b1   // larger shift
  } scale_e;
endpackage

// File: rtl/cmul_products.sv
// Full-precision complex product, combinational.
module cmul_products #(
  parameter int W = 20
) (
  input  logic [2*W-1:0]        a,
  input  logic [2*W-1:0]        b,
  output logic signed [2*W:0]   full [2]   // [0] real, [1] imaginary
);
  localparam int MW = 2 * W;

  logic signed [W-1:0]  ar, ai, br, bi;
  logic signed [MW-1:0] p_rr, p_ii, p_ri, p_ir;

  assign ar = a[2*W-1:W];
  assign ai = a[W-1:0];
  assign br = b[2*W-1:W];
  assign bi = b[W-1:0];

  always_comb begin
    p_rr = MW'(ar) * MW'(br);
    p_ii = MW'(ai) * MW'(bi);
    p_ri = MW'(ar) * MW'(bi);
    p_ir = MW'(ai) * MW'(br);
    full[0] = {p_rr[MW-1], p_rr} - {p_ii[MW-1], p_ii};
    full[1] = {p_ri[MW-1], p_ri} + {p_ir[MW-1], p_ir};
  end
endmodule

// File: rtl/cmul_scaler.sv
// Round-half-up shift by one of two amounts, then clamp to OW bits.
module cmul_scaler
  import cmul_pkg::*;
#(
  parameter int IW        = 41,
  parameter int OW        = 20,
  parameter int SH_COARSE = 18,
  parameter int SH_FINE   = 14
) (
  input  logic signed [IW-1:0] din,
  input  scale_e               mode,
  output logic [OW-1:0]        dout
);
  localparam logic signed [IW:0] MAXV = {{(IW-OW+2){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [IW:0] MINV = {{(IW-OW+2){1'b1}}, {(OW-1){1'b0}}};
  localparam logic signed [IW:0] ONE  = {{IW{1'b0}}, 1'b1};
  localparam logic signed [IW:0] BIAS_C = ONE <<< (SH_COARSE - 1);
  localparam logic signed [IW:0] BIAS_F = ONE <<< (SH_FINE - 1);

  logic signed [IW:0] ext, rnd_c, rnd_f, shifted;

  always_comb begin
    ext     = {din[IW-1], din};
    rnd_c   = ext + BIAS_C;
    rnd_f   = ext + BIAS_F;
    shifted = (mode == SCALE_COARSE) ? (rnd_c >>> SH_COARSE)
                                     : (rnd_f >>> SH_FINE);
    if (shifted > MAXV)      dout = MAXV[OW-1:0];
    else if (shifted < MINV) dout = MINV[OW-1:0];
    else                     dout = shifted[OW-1:0];
  end
endmodule

// File: rtl/cmul_top.sv
module cmul_top
  import cmul_pkg::*;
#(
  parameter int W         = 20,
  parameter int SH_COARSE = 18,
  parameter int SH_FINE   = 14,
  parameter bit MID_REG   = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_vld,
  input  logic [2*W-1:0] op_a,
  input  logic [2*W-1:0] op_b,
  input  logic           scale_sel,
  output logic           out_vld,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W + 1;

  logic signed [PW-1:0] full_c [2];
  logic signed [PW-1:0] mid_full [2];
  scale_e               mid_mode;
  logic                 mid_vld;
  logic [W-1:0]         part [2];

  cmul_products #(.W(W)) u_products (
    .a    (op_a),
    .b    (op_b),
    .full (full_c)
  );

  generate
    if (MID_REG) begin : g_mid
      always_ff @(posedge clk) begin
        if (rst) begin
          mid_vld     <= 1'b0;
          mid_mode    <= SCALE_FINE;
          mid_full[0] <= '0;
          mid_full[1] <= '0;
        end else begin
          mid_vld <= in_vld;
          if (in_vld) begin
            mid_mode    <= scale_e'(scale_sel);
            mid_full[0] <= full_c[0];
            mid_full[1] <= full_c[1];
          end
        end
      end
    end else begin : g_nomid
      assign mid_vld     = in_vld;
      assign mid_mode    = scale_e'(scale_sel);
      assign mid_full[0] = full_c[0];
      assign mid_full[1] = full_c[1];
    end
  endgenerate

  for (genvar c = 0; c < 2; c++) begin : g_part
    cmul_scaler #(
      .IW(PW), .OW(W), .SH_COARSE(SH_COARSE), .SH_FINE(SH_FINE)
    ) u_scaler (
      .din  (mid_full[c]),
      .mode (mid_mode),
      .dout (part[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      prod    <= '0;
    end else begin
      out_vld <= mid_vld;
      if (mid_vld) prod <= {part[0], part[1]};
    end
  end
endmodule

// File: rtl/cmul_top_chk.sv
module cmul_top_chk #(
  parameter int W   = 20,
  parameter int LAT = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           in_vld,
  input logic [2*W-1:0] op_a,
  input logic           out_vld,
  input logic [2*W-1:0] prod
);
  logic [1:0] age;
  logic       rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R8: valid strobe follows input valid by the latency
  assert_vld_latency_R8: assert property (@(posedge clk) disable iff (rst)
    (age > 2'(LAT)) |-> (out_vld == $past(in_vld, LAT)));

  // R9: result holds while no new result arrives
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && !out_vld) |-> $stable(prod));

  // R2 and R3: zero first operand gives zero result
  assert_zero_prod_R2: assert property (@(posedge clk) disable iff (rst)
    (age > 2'(LAT) && out_vld && $past(op_a, LAT) == '0) |-> (prod == '0));

  // R10: outputs cleared right after a reset cycle
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst_q |-> (!out_vld && prod == '0));
endmodule

bind cmul_top cmul_top_chk #(.W(W), .LAT(MID_REG ? 2 : 1)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .in_vld  (in_vld),
  .op_a    (op_a),
  .out_vld (out_vld),
  .prod    (prod)
);

// File: tb/test_cmul_top.sv
module test_cmul_top;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 20;
  localparam int LAT = 2;
  localparam int MAXP = (1 << (W - 1)) - 1;
  localparam int MINP = -(1 << (W - 1));

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_vld = 1'b0;
  logic [39:0]   op_a = '0;
  logic [39:0]   op_b = '0;
  logic          scale_sel = 1'b0;
  logic          out_vld;
  logic [39:0]   prod;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cmul_top #(.W(W), .SH_COARSE(18), .SH_FINE(14), .MID_REG(1'b1)) i_cmul_top (
    .clk(clk), .rst(rst), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
    .scale_sel(scale_sel), .out_vld(out_vld), .prod(prod)
  );

  function automatic logic [39:0] pack(input int re, input int im);
    return {re[19:0], im[19:0]};
  endfunction

  function automatic longint sx(input logic [19:0] v);
    return longint'(signed'(v));
  endfunction

  function automatic logic [19:0] scale_one(input longint v, input bit sel);
    int sh = sel ? 18 : 14;
    longint r = (v + (64'sd1 <<< (sh - 1))) >>> sh;
    if (r > MAXP) r = MAXP;
    if (r < MINP) r = MINP;
    return r[19:0];
  endfunction

  // Reference model built from R1..R7
  function automatic logic [39:0] model(input logic [39:0] a, input logic [39:0] b,
                                        input bit sel);
    longint re = sx(a[39:20]) * sx(b[39:20]) - sx(a[19:0]) * sx(b[19:0]);
    longint im = sx(a[39:20]) * sx(b[19:0]) + sx(a[19:0]) * sx(b[39:20]);
    return {scale_one(re, sel), scale_one(im, sel)};
  endfunction

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Single operation: drive at negedge, sample LAT negedges later.
  task automatic apply(input string req, input logic [39:0] a, input logic [39:0] b,
                       input bit sel);
    logic [39:0] exp = model(a, b, sel);
    @(negedge clk);
    op_a = a; op_b = b; scale_sel = sel; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0; op_a = $urandom; op_b = $urandom; scale_sel = ~sel;
    repeat (LAT - 1) @(negedge clk);
    chk({req, " out_vld"}, {39'd0, out_vld}, 40'd1);
    chk(req, prod, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R10 out_vld in reset", {39'd0, out_vld}, 40'd0);
    chk("R10 prod in reset", prod, 40'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 out_vld after reset", {39'd0, out_vld}, 40'd0);
    chk("R10 prod after reset", prod, 40'd0);
  endtask

  task automatic t_basic;
    apply("R1 R2 R3 zero operand", pack(0, 0), pack(12345, -777), 1'b0);
    apply("R2 R5 real-only", pack(3 << 14, 0), pack(5, 0), 1'b0);
    apply("R3 R4 imag cross", pack(1 << 10, 1 << 9), pack(1 << 9, 1 << 10), 1'b1);
    apply("R1 R5 mixed signs", pack(-1000, 2000), pack(3000, -4000), 1'b0);
  endtask

  task automatic t_rounding;
    apply("R6 half up coarse", pack(1, 0), pack(1 << 17, 0), 1'b1);        // 1
    apply("R6 below half coarse", pack(1, 0), pack((1 << 17) - 1, 0), 1'b1); // 0
    apply("R6 neg half coarse", pack(-1, 0), pack(1 << 17, 0), 1'b1);       // 0
    apply("R6 half up fine", pack(1, 0), pack(3 << 13, 0), 1'b0);           // 2
    apply("R6 neg half fine", pack(-1, 0), pack(3 << 13, 0), 1'b0);         // -1
  endtask

  task automatic t_saturate;
    apply("R7 most negative squared coarse", pack(MINP, 0), pack(MINP, 0), 1'b1);
    apply("R7 most negative squared fine", pack(MINP, MINP), pack(MINP, MINP), 1'b0);
    apply("R7 low clamp", pack(MINP, 0), pack(MAXP, 0), 1'b0);
    apply("R7 full-negative cross coarse", pack(MINP, MINP), pack(MAXP, MINP), 1'b1);
  endtask

  task automatic t_hold;
    logic [39:0] held;
    apply("R9 setup", pack(4000, -5000), pack(6000, 7000), 1'b0);
    held = prod;
    for (int k = 0; k < 4; k++) begin
      op_a = $urandom; op_b = $urandom;
      @(negedge clk);
      chk("R9 out_vld low", {39'd0, out_vld}, 40'd0);
      chk("R9 prod held", prod, held);
    end
  endtask

  task automatic t_stream;
    logic [39:0] ea [8];
    bit          es [8];
    for (int k = 0; k < 8 + LAT; k++) begin
      @(negedge clk);
      if (k >= LAT) begin
        chk("R8 stream valid", {39'd0, out_vld}, {39'd0, es[k-LAT]});
        if (es[k-LAT]) chk("R8 stream scale pairing", prod, ea[k-LAT]);
      end
      if (k < 8) begin
        op_a = {$urandom, $urandom}; op_b = {$urandom, $urandom};
        scale_sel = k[0];
        in_vld = (k != 5);
        es[k] = in_vld;
        ea[k] = model(op_a, op_b, scale_sel);
      end else in_vld = 1'b0;
    end
  endtask

  task automatic t_random;
    for (int k = 0; k < 40; k++) begin
      logic [39:0] a = {$urandom, $urandom};
      logic [39:0] b = {$urandom, $urandom};
      apply(k[0] ? "R4 random coarse" : "R5 random fine", a, b, k[0]);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_rounding();
    t_saturate();
    t_hold();
    t_stream();
    t_random();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule